// File: doc/BRIEF.md
# Two-Buffer Word Copy Engine

This block moves 32-bit words between two on-chip memories: a USB endpoint buffer with a 10-bit word address and an E1 frame buffer with a 14-bit word address. Software first sets a start word offset for each buffer through a small 32-bit register bus. It then writes a command word that holds a one-bit direction and a length, and that write starts the copy. While the copy runs, a status readback shows a busy flag, the direction and a remaining-length count.

Each memory is a simple synchronous RAM port that returns read data one cycle after the request. The engine reads one source word per cycle. It writes each word to the destination in the cycle after its read, so source reads stay one cycle ahead of destination writes. Both offsets step forward as words move, which means a second copy continues where the first one stopped. The memory ports are plain enable/address/data ports and do not back-pressure: the RAMs accept a request on every cycle. The register bus is also plain, with a write strobe and a read path decoded from the address alone.

Top module: `wcopy_dma`

## Requirements
- R1: A register write to byte offset 0x0 while idle starts a copy. Bit 14 of the written word is the direction and bits [11:0] are the length code L. In the next cycle the status read at offset 0x0 shows busy (bit 15) = 1, bit 14 = the direction, and bits [12:0] = L+1.
- R2: A copy moves exactly L+2 words. The engine reads consecutive source offsets starting at the programmed source offset. Each word read is written unchanged to consecutive destination offsets starting at the programmed destination offset, one cycle after its read.
- R3: With direction 0 the engine reads the E1 buffer and writes the USB buffer. With direction 1 it reads the USB buffer and writes the E1 buffer. It never writes the source buffer, and it never reads both buffers or writes both buffers in the same cycle.
- R4: The remaining length in status bits [12:0] drops by one for each word written. Once the copy has finished it reads as 0x1FFF.
- R5: Busy clears in the cycle that follows the final destination write. While idle, no memory port is enabled.
- R6: Offset 0x8 holds the 14-bit E1 word offset and offset 0xC holds the 10-bit USB word offset. Both are readable and writable. After a copy of N words each offset has advanced by N, wrapping at its own width, and memory addresses wrap the same way during the copy.
- R7: While busy, writes to offsets 0x0, 0x8 and 0xC are ignored. The running copy, its direction, its length and both offsets are unaffected.
- R8: Register bits outside the defined fields read as zero, and offset 0x4 reads as zero.
- R9: After reset the block is idle with both offsets at zero and the remaining length at 0x1FFF. The status word reads 0x00001FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset (bits [1:0] ignored) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded from reg_addr |
| usb_rd_en | output | 1 | USB buffer read request |
| usb_rd_addr | output | 10 | USB buffer read word address |
| usb_rd_data | input | 32 | USB buffer read data, valid the cycle after the request |
| usb_wr_en | output | 1 | USB buffer write enable |
| usb_wr_addr | output | 10 | USB buffer write word address |
| usb_wr_data | output | 32 | USB buffer write data |
| e1_rd_en | output | 1 | E1 buffer read request |
| e1_rd_addr | output | 14 | E1 buffer read word address |
| e1_rd_data | input | 32 | E1 buffer read data, valid the cycle after the request |
| e1_wr_en | output | 1 | E1 buffer write enable |
| e1_wr_addr | output | 14 | E1 buffer write word address |
| e1_wr_data | output | 32 | E1 buffer write data |

## Verification
The assertions check the port discipline on every cycle. They cover one-sided reads and writes, no write to the source, every write preceded by a read, unit address steps between back-to-back writes, quiet ports and an all-ones count while idle, and busy falling only right after a write. Only the bench scenarios can show the end-to-end properties. These are the word count, the exact source-to-destination data and address mapping in both directions, the final offsets after wrap-around, the count readback as the copy runs, and the fact that commands and offset writes issued mid-copy leave the copy untouched.

// File: rtl/wcopy_dma_pkg.sv
package wcopy_dma_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_CTRL = 0;
  localparam int IDX_E1   = 2;
  localparam int IDX_USB  = 3;
  localparam int BUSY_BIT = 15;
  localparam int DIR_BIT  = 14;

  typedef enum logic {
    DIR_E1_TO_USB = 1'b0,
    DIR_USB_TO_E1 = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/wcopy_dma_seq.sv
module wcopy_dma_seq #(
  parameter int LEN_W = 12,
  localparam int REM_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_code,
  output logic             busy,
  output logic             rd_go,
  output logic             wr_go,
  output logic [REM_W-1:0] rem
);
  logic [REM_W-1:0] rd_left;

  assign rd_go = busy && (rd_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_left <= '0;
      wr_go   <= 1'b0;
      rem     <= '1;
    end else begin
      wr_go <= rd_go;
      if (start && !busy) begin
        busy    <= 1'b1;
        rd_left <= {1'b0, len_code} + REM_W'(2);
        rem     <= {1'b0, len_code} + REM_W'(1);
      end else begin
        if (rd_go) rd_left <= rd_left - REM_W'(1);
        if (wr_go) begin
          rem <= rem - REM_W'(1);
          if (rem == '0) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wcopy_dma_ptr.sv
module wcopy_dma_ptr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (step)  q <= q + AW'(1);
  end
endmodule

// File: rtl/wcopy_dma.sv
module wcopy_dma
  import wcopy_dma_pkg::*;
#(
  parameter int USB_AW = 10,
  parameter int E1_AW  = 14,
  parameter int LEN_W  = 12,
  localparam int REM_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              usb_rd_en,
  output logic [USB_AW-1:0] usb_rd_addr,
  input  logic [DATA_W-1:0] usb_rd_data,
  output logic              usb_wr_en,
  output logic [USB_AW-1:0] usb_wr_addr,
  output logic [DATA_W-1:0] usb_wr_data,
  output logic              e1_rd_en,
  output logic [E1_AW-1:0]  e1_rd_addr,
  input  logic [DATA_W-1:0] e1_rd_data,
  output logic              e1_wr_en,
  output logic [E1_AW-1:0]  e1_wr_addr,
  output logic [DATA_W-1:0] e1_wr_data
);
  logic [1:0]       idx;
  logic             busy, rd_go, wr_go;
  logic [REM_W-1:0] rem;
  xfer_dir_e        dir_q;
  logic             wr_ok, start;
  logic [E1_AW-1:0]  e1_q;
  logic [USB_AW-1:0] usb_q;
  logic             e1_step, usb_step;

  assign idx   = reg_addr[3:2];
  assign wr_ok = reg_we && !busy;
  assign start = wr_ok && (idx == 2'(IDX_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n)     dir_q <= DIR_E1_TO_USB;
    else if (start) dir_q <= xfer_dir_e'(reg_wdata[DIR_BIT]);
  end

  wcopy_dma_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .len_code(reg_wdata[LEN_W-1:0]),
    .busy(busy), .rd_go(rd_go), .wr_go(wr_go), .rem(rem)
  );

  assign e1_step  = (dir_q == DIR_USB_TO_E1) ? wr_go : rd_go;
  assign usb_step = (dir_q == DIR_USB_TO_E1) ? rd_go : wr_go;

  wcopy_dma_ptr #(.AW(E1_AW)) u_e1_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ok && (idx == 2'(IDX_E1))),
    .load_val(reg_wdata[E1_AW-1:0]),
    .step(e1_step), .q(e1_q)
  );

  wcopy_dma_ptr #(.AW(USB_AW)) u_usb_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ok && (idx == 2'(IDX_USB))),
    .load_val(reg_wdata[USB_AW-1:0]),
    .step(usb_step), .q(usb_q)
  );

  assign usb_rd_en   = rd_go && (dir_q == DIR_USB_TO_E1);
  assign e1_rd_en    = rd_go && (dir_q == DIR_E1_TO_USB);
  assign usb_wr_en   = wr_go && (dir_q == DIR_E1_TO_USB);
  assign e1_wr_en    = wr_go && (dir_q == DIR_USB_TO_E1);
  assign usb_rd_addr = usb_q;
  assign usb_wr_addr = usb_q;
  assign e1_rd_addr  = e1_q;
  assign e1_wr_addr  = e1_q;
  assign usb_wr_data = e1_rd_data;
  assign e1_wr_data  = usb_rd_data;

  always_comb begin
    reg_rdata = '0;
    case (idx)
      2'(IDX_CTRL): begin
        reg_rdata[BUSY_BIT]  = busy;
        reg_rdata[DIR_BIT]   = dir_q;
        reg_rdata[REM_W-1:0] = rem;
      end
      2'(IDX_E1):  reg_rdata[E1_AW-1:0]  = e1_q;
      2'(IDX_USB): reg_rdata[USB_AW-1:0] = usb_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wcopy_dma_chk.sv
module wcopy_dma_chk #(
  parameter int USB_AW = 10,
  parameter int E1_AW  = 14,
  parameter int REM_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [REM_W-1:0]  rem,
  input logic              usb_rd_en,
  input logic              usb_wr_en,
  input logic [USB_AW-1:0] usb_wr_addr,
  input logic              e1_rd_en,
  input logic              e1_wr_en,
  input logic [E1_AW-1:0]  e1_wr_addr
);
  p_one_side_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(usb_rd_en && e1_rd_en));
  p_one_side_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(usb_wr_en && e1_wr_en));
  p_no_usb_src_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rd_en |-> !usb_wr_en);
  p_no_e1_src_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    e1_rd_en |-> !e1_wr_en);
  p_wr_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_wr_en || e1_wr_en) |-> $past(usb_rd_en || e1_rd_en));
  p_usb_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_wr_en && $past(usb_wr_en)) |-> usb_wr_addr == $past(usb_wr_addr) + USB_AW'(1));
  p_e1_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_wr_en && $past(e1_wr_en)) |-> e1_wr_addr == $past(e1_wr_addr) + E1_AW'(1));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(usb_rd_en || e1_rd_en || usb_wr_en || e1_wr_en));
  p_idle_allones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rem == '1);
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(usb_wr_en || e1_wr_en));
endmodule

bind wcopy_dma wcopy_dma_chk #(.USB_AW(USB_AW), .E1_AW(E1_AW), .REM_W(REM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rem(rem),
  .usb_rd_en(usb_rd_en), .usb_wr_en(usb_wr_en), .usb_wr_addr(usb_wr_addr),
  .e1_rd_en(e1_rd_en), .e1_wr_en(e1_wr_en), .e1_wr_addr(e1_wr_addr)
);

// File: tb/wcopy_dma_tb.sv
module wcopy_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        usb_rd_en, usb_wr_en, e1_rd_en, e1_wr_en;
  logic [9:0]  usb_rd_addr, usb_wr_addr;
  logic [13:0] e1_rd_addr, e1_wr_addr;
  logic [31:0] usb_rd_data = '0, e1_rd_data = '0, usb_wr_data, e1_wr_data;

  int checks = 0, fails = 0, cyc = 0, wcnt = 0, last_wr_cyc = 0;
  int e1_cur = 0, usb_cur = 0;

  typedef struct { logic to_e1; int addr; logic [31:0] data; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  wcopy_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .usb_rd_en(usb_rd_en), .usb_rd_addr(usb_rd_addr), .usb_rd_data(usb_rd_data),
    .usb_wr_en(usb_wr_en), .usb_wr_addr(usb_wr_addr), .usb_wr_data(usb_wr_data),
    .e1_rd_en(e1_rd_en), .e1_rd_addr(e1_rd_addr), .e1_rd_data(e1_rd_data),
    .e1_wr_en(e1_wr_en), .e1_wr_addr(e1_wr_addr), .e1_wr_data(e1_wr_data)
  );

  function automatic logic [31:0] usb_pat(int a);
    return 32'hB5B0_0000 | 32'(a);
  endfunction
  function automatic logic [31:0] e1_pat(int a);
    return 32'hE100_0000 | 32'(a);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (usb_rd_en) usb_rd_data <= usb_pat(int'(usb_rd_addr));
    if (e1_rd_en)  e1_rd_data  <= e1_pat(int'(e1_rd_addr));
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every destination write
  always @(negedge clk) begin
    if (rst_n && (usb_wr_en || e1_wr_en)) begin
      wcnt++;
      last_wr_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected write", {31'b0, e1_wr_en}, 32'h0);
      end else begin
        item_t it;
        logic [31:0] ad, dd;
        it = exp_q.pop_front();
        ad = e1_wr_en ? 32'(e1_wr_addr) : 32'(usb_wr_addr);
        dd = e1_wr_en ? e1_wr_data : usb_wr_data;
        check(e1_wr_en == it.to_e1 && usb_wr_en == !it.to_e1, "R3 dest side", {31'b0, e1_wr_en}, {31'b0, it.to_e1});
        check(ad == 32'(it.addr), "R2 dest addr", ad, 32'(it.addr));
        check(dd == it.data, "R2 dest data", dd, it.data);
      end
    end
  end

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Driver: programs offsets (optional), pushes expectations, starts, polls
  task automatic run_xfer(input bit dir, input int len, input bit set_ofs,
                          input int e1o, input int usbo, input bit poke);
    logic [31:0] d;
    int n;
    n = len + 2;
    if (set_ofs) begin
      wr(4'h8, 32'(e1o)); wr(4'hC, 32'(usbo));
      e1_cur = e1o; usb_cur = usbo;
      rd(4'h8, d); check(d == 32'(e1o), "R6 e1 ofs readback", d, 32'(e1o));
      rd(4'hC, d); check(d == 32'(usbo), "R6 usb ofs readback", d, 32'(usbo));
    end
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.to_e1 = dir;
      if (dir) begin
        it.addr = (e1_cur + k) % 16384;
        it.data = usb_pat((usb_cur + k) % 1024);
      end else begin
        it.addr = (usb_cur + k) % 1024;
        it.data = e1_pat((e1_cur + k) % 16384);
      end
      exp_q.push_back(it);
    end
    wcnt = 0;
    wr(4'h0, (32'(dir) << 14) | 32'(len));
    rd(4'h0, d);
    check(d == ((32'h1 << 15) | (32'(dir) << 14) | 32'(len + 1)), "R1 start status", d,
          (32'h1 << 15) | (32'(dir) << 14) | 32'(len + 1));
    if (poke) begin
      wr(4'h0, (32'(!dir) << 14) | 32'd3);
      wr(4'h8, 32'h0);
      wr(4'hC, 32'h0);
      rd(4'h0, d);
      check(d[14] == dir, "R7 dir kept", {31'b0, d[14]}, {31'b0, dir});
    end
    forever begin
      rd(4'h0, d);
      if (!d[15]) break;
      begin
        int wr_now, expr;
        wr_now = (usb_wr_en || e1_wr_en) ? 1 : 0;
        expr = len + 1 - (wcnt - wr_now);
        check(d[12:0] == 13'(expr), "R4 remaining count", {19'b0, d[12:0]}, 32'(expr) & 32'h1FFF);
      end
      @(negedge clk);
    end
    check(d == (32'(dir) << 14 | 32'h1FFF), "R4 done status", d, 32'(dir) << 14 | 32'h1FFF);
    check(cyc == last_wr_cyc + 1, "R5 busy clear timing", 32'(cyc), 32'(last_wr_cyc + 1));
    check(wcnt == n && exp_q.size() == 0, "R2 word count", 32'(wcnt), 32'(n));
    e1_cur = (e1_cur + n) % 16384;
    usb_cur = (usb_cur + n) % 1024;
    rd(4'h8, d); check(d == 32'(e1_cur), "R6 e1 ofs advanced", d, 32'(e1_cur));
    rd(4'hC, d); check(d == 32'(usb_cur), "R6 usb ofs advanced", d, 32'(usb_cur));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, d); check(d == 32'h0000_1FFF, "R9 reset status", d, 32'h0000_1FFF);
    rd(4'h8, d); check(d == 32'h0, "R9 reset e1 ofs", d, 32'h0);
    rd(4'hC, d); check(d == 32'h0, "R9 reset usb ofs", d, 32'h0);
    rd(4'h4, d); check(d == 32'h0, "R8 hole reads zero", d, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); check(d == 32'h0000_3FFF, "R8 e1 ofs unused bits", d, 32'h0000_3FFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); check(d == 32'h0000_03FF, "R8 usb ofs unused bits", d, 32'h0000_03FF);

    run_xfer(1'b1, 0, 1'b1, 5, 7, 1'b0);          // R3 USB->E1 shortest
    run_xfer(1'b0, 5, 1'b1, 100, 20, 1'b0);       // R3 E1->USB
    run_xfer(1'b1, 12, 1'b1, 300, 40, 1'b1);      // R7 writes while busy
    run_xfer(1'b0, 2, 1'b1, 16382, 1022, 1'b0);   // R6 wrap both
    run_xfer(1'b1, 1, 1'b0, 0, 0, 1'b0);          // R6 auto-advance continues
    run_xfer(1'b0, 4095, 1'b1, 50, 1000, 1'b0);   // R2 max length

    rd(4'h0, d);
    check((d & 32'hFFFF_2000) == 32'h0, "R8 status unused bits", d & 32'hFFFF_2000, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule